// File: doc/BRIEF.md
# Hypervisor-Only Interrupt Entry and Return Sequencer

This block decides what happens when the pipeline reports an exception or retires a return-from-interrupt instruction, on a core that has no partitioning support and so runs permanently in hypervisor state. On each clock it takes the exception and return requests from the head of the pipeline and picks one by a fixed priority. For an interrupt entry it computes the vector address, saves the return address and the machine state into one of two save/restore register pairs, and clears the external-interrupt enable. For a return it branches to the saved address and reloads the saved machine state.

Illegal instructions take a dedicated emulation-assist interrupt that also records the offending instruction word. Both that interrupt and the external interrupt are hypervisor-class and use the hypervisor save pair. Alignment and ordinary program traps use the ordinary pair. The two return instructions differ only in which pair they read. The machine-state hypervisor bit is wired to one: no interrupt entry, return or pipeline write can clear it. A redirect strobe, together with the target address, tells the fetch unit where to continue.

Top module: `hv_trap_seq`

## Requirements
- R1: While reset is asserted and afterwards until the first accepted event, `msr` holds only bit 60 (the hypervisor bit). `srr0`, `srr1`, `hsrr0`, `hsrr1` and `heir` are zero, and `redirect` is low.
- R2: Bit 60 of `msr` reads as 1 in every cycle, including after a pipeline write or a return whose data has that bit clear.
- R3: An accepted illegal-instruction request redirects to VEC_BASE + 0xE40 and loads `heir` with `ill_word`, `hsrr0` with `cur_pc` and `hsrr1` with the prior `msr`. `srr0` and `srr1` are left unchanged.
- R4: An external request is accepted only when `msr` bit 15 (external enable) is 1. It then redirects to VEC_BASE + 0x500 and loads `hsrr0` with `nxt_pc` and `hsrr1` with the prior `msr`. When bit 15 is 0 it produces no redirect and changes no output.
- R5: An accepted alignment request redirects to VEC_BASE + 0x600 and loads `srr0` with `cur_pc`, which is the address of the faulting instruction itself, and `srr1` with the prior `msr`. `hsrr0` and `hsrr1` are left unchanged.
- R6: An accepted program-trap request redirects to VEC_BASE + 0x700 and loads `srr0` with `cur_pc` and `srr1` with the prior `msr`.
- R7: Every interrupt entry sets `msr` to its prior value with bit 15 cleared and all other bits kept.
- R8: An accepted `rfi_req` redirects to `srr0` and loads `msr` from `srr1`. An accepted `hrfi_req` does the same using `hsrr0` and `hsrr1`. In both cases bit 60 is forced to 1.
- R9: When several requests are present in one cycle, exactly one acts. The order from highest to lowest is: illegal, alignment, trap, hypervisor return, normal return, enabled external, machine-state write. The losing requests have no effect.
- R10: `redirect` is high for exactly the one cycle after an accepted entry or return and low in every other cycle. `redirect_pc` carries the target in that cycle.
- R11: With no other accepted event, `msr_wr` loads `msr` with `msr_wdata`, with bit 60 forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ill_req | input | 1 | Head instruction is illegal |
| ill_word | input | 32 | Instruction word of the head instruction |
| algn_req | input | 1 | Head instruction took an alignment fault |
| trap_req | input | 1 | Head instruction took a program trap |
| ext_req | input | 1 | External interrupt pending (level) |
| rfi_req | input | 1 | Normal return instruction retiring |
| hrfi_req | input | 1 | Hypervisor return instruction retiring |
| msr_wr | input | 1 | Pipeline write of the machine state |
| msr_wdata | input | 64 | Data for the machine-state write |
| cur_pc | input | 64 | Address of the head instruction |
| nxt_pc | input | 64 | Address of the next instruction to execute |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 64 | Redirect target address |
| msr | output | 64 | Machine state |
| srr0 | output | 64 | Ordinary saved return address |
| srr1 | output | 64 | Ordinary saved machine state |
| hsrr0 | output | 64 | Hypervisor saved return address |
| hsrr1 | output | 64 | Hypervisor saved machine state |
| heir | output | 32 | Captured emulation-assist instruction word |

## Verification
The bench aims at the places where pair routing is easy to get wrong. It raises illegal and external requests and checks that the ordinary pair stays untouched; a design that routed them to the ordinary pair would fail that check and also lose whatever an earlier alignment fault had saved. It holds external requests while the enable bit is clear, where a missing mask would produce a spurious redirect. It raises every request in the same cycle, where a wrong priority would vector to the wrong offset or save the wrong address. It also drives writes and returns whose data has the hypervisor bit clear, which a design that failed to force the bit would pass straight through to `msr`.

// File: rtl/hvt_pkg.sv
// Shared types for the interrupt entry/return sequencer.
// Assumes event encoding order matches the arbiter's request vector order.
package hvt_pkg;

    // Winning event of one cycle; value-1 equals its request index.
    typedef enum logic [2:0] {
        EV_NONE = 3'd0,
        EV_ILL  = 3'd1,
        EV_ALGN = 3'd2,
        EV_TRAP = 3'd3,
        EV_HRFI = 3'd4,
        EV_RFI  = 3'd5,
        EV_EXT  = 3'd6,
        EV_MSRW = 3'd7
    } hvt_ev_e;

    localparam int unsigned NUM_SRC = 7;

    localparam logic [11:0] OFF_EMUL = 12'hE40;
    localparam logic [11:0] OFF_EXT  = 12'h500;
    localparam logic [11:0] OFF_ALGN = 12'h600;
    localparam logic [11:0] OFF_TRAP = 12'h700;

    // Low vector offset of an interrupt entry.
    function automatic logic [11:0] vec_offset(hvt_ev_e ev);
        case (ev)
            EV_ILL:  return OFF_EMUL;
            EV_EXT:  return OFF_EXT;
            EV_ALGN: return OFF_ALGN;
            EV_TRAP: return OFF_TRAP;
            default: return 12'h000;
        endcase
    endfunction

    // True for events that enter an interrupt.
    function automatic logic is_entry(hvt_ev_e ev);
        return (ev == EV_ILL) || (ev == EV_ALGN) || (ev == EV_TRAP) || (ev == EV_EXT);
    endfunction

    // True for interrupts that use the hypervisor save pair.
    function automatic logic to_hyper(hvt_ev_e ev);
        return (ev == EV_ILL) || (ev == EV_EXT);
    endfunction

endpackage

// File: rtl/hvt_arbiter.sv
// Fixed-priority picker: request index 0 is the highest priority.
// Assumes the request vector is already masked (external by enable bit).
module hvt_arbiter
    import hvt_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC
) (
    input  logic [NSRC-1:0] req,
    output hvt_ev_e         win
);

    // Scan from lowest priority up so the highest set request wins.
    always_comb begin
        win = EV_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                win = hvt_ev_e'(3'(i + 1));
            end
        end
    end

endmodule

// File: rtl/hvt_save.sv
// Save/restore register bank: an ordinary pair, a hypervisor pair and the
// emulation-instruction capture register. Assumes at most one event per cycle.
module hvt_save
    import hvt_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned IW   = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  hvt_ev_e         ev,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] nxt_pc,
    input  logic [XLEN-1:0] msr_q,
    input  logic [IW-1:0]   ill_word,
    output logic [XLEN-1:0] srr0,
    output logic [XLEN-1:0] srr1,
    output logic [XLEN-1:0] hsrr0,
    output logic [XLEN-1:0] hsrr1,
    output logic [IW-1:0]   heir
);

    localparam int unsigned NPAIR = 2;

    logic [XLEN-1:0] save_addr;
    logic [IW-1:0]   heir_q;

    // Return address: external resumes at the next instruction, others at the faulting one.
    assign save_addr = (ev == EV_EXT) ? nxt_pc : cur_pc;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        logic [XLEN-1:0] addr_q;
        logic [XLEN-1:0] state_q;
        logic            hit;

        assign hit = is_entry(ev) && (to_hyper(ev) == (g == 1));

        // Capture return address and prior machine state on an entry routed to this pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q  <= '0;
                state_q <= '0;
            end else if (hit) begin
                addr_q  <= save_addr;
                state_q <= msr_q;
            end
        end
    end

    // Record the illegal instruction word on an emulation-assist entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            heir_q <= '0;
        end else if (ev == EV_ILL) begin
            heir_q <= ill_word;
        end
    end

    assign srr0  = g_pair[0].addr_q;
    assign srr1  = g_pair[0].state_q;
    assign hsrr0 = g_pair[1].addr_q;
    assign hsrr1 = g_pair[1].state_q;
    assign heir  = heir_q;

endmodule

// File: rtl/hvt_msr.sv
// Machine-state register with the hypervisor bit pinned to one.
// Assumes the save pairs present their values before this cycle's update.
module hvt_msr
    import hvt_pkg::*;
#(
    parameter int unsigned XLEN   = 64,
    parameter int unsigned HV_POS = 60,
    parameter int unsigned EE_POS = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  hvt_ev_e         ev,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] srr1,
    input  logic [XLEN-1:0] hsrr1,
    output logic [XLEN-1:0] msr_q
);

    localparam logic [XLEN-1:0] HV_MASK = XLEN'(1) << HV_POS;
    localparam logic [XLEN-1:0] EE_MASK = XLEN'(1) << EE_POS;

    logic [XLEN-1:0] msr_d;
    logic [XLEN-1:0] msr_r;

    // Select the next machine state for this cycle's event, then pin the hypervisor bit.
    always_comb begin
        case (ev)
            EV_ILL, EV_ALGN, EV_TRAP, EV_EXT: msr_d = msr_r & ~EE_MASK;
            EV_RFI:  msr_d = srr1;
            EV_HRFI: msr_d = hsrr1;
            EV_MSRW: msr_d = wdata;
            default: msr_d = msr_r;
        endcase
        msr_d = msr_d | HV_MASK;
    end

    // Machine-state register; reset leaves only the hypervisor bit set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msr_r <= HV_MASK;
        end else begin
            msr_r <= msr_d;
        end
    end

    assign msr_q = msr_r;

endmodule

// File: rtl/hvt_redir.sv
// Fetch redirect generator: one-cycle strobe plus registered target.
// Assumes the save pairs present their values before this cycle's update.
module hvt_redir
    import hvt_pkg::*;
#(
    parameter int unsigned     XLEN     = 64,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  hvt_ev_e         ev,
    input  logic [XLEN-1:0] srr0,
    input  logic [XLEN-1:0] hsrr0,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc
);

    logic [XLEN-1:0] tgt;
    logic            fire;
    logic            fire_q;
    logic [XLEN-1:0] tgt_q;

    // Target: vector for entries, saved address for returns.
    always_comb begin
        case (ev)
            EV_RFI:  tgt = srr0;
            EV_HRFI: tgt = hsrr0;
            default: tgt = VEC_BASE + XLEN'(vec_offset(ev));
        endcase
        fire = is_entry(ev) || (ev == EV_RFI) || (ev == EV_HRFI);
    end

    // Register strobe and target for the fetch unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_q <= 1'b0;
            tgt_q  <= '0;
        end else begin
            fire_q <= fire;
            if (fire) begin
                tgt_q <= tgt;
            end
        end
    end

    assign redirect    = fire_q;
    assign redirect_pc = tgt_q;

endmodule

// File: rtl/hv_trap_seq.sv
// Interrupt entry and return sequencer for a core fixed in hypervisor state.
// Assumes the request inputs all refer to the instruction at the head of the
// pipeline and that cur_pc/nxt_pc/ill_word are valid whenever a request is.
module hv_trap_seq
    import hvt_pkg::*;
#(
    parameter int unsigned     XLEN     = 64,
    parameter int unsigned     IW       = 32,
    parameter int unsigned     HV_POS   = 60,
    parameter int unsigned     EE_POS   = 15,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ill_req,
    input  logic [IW-1:0]   ill_word,
    input  logic            algn_req,
    input  logic            trap_req,
    input  logic            ext_req,
    input  logic            rfi_req,
    input  logic            hrfi_req,
    input  logic            msr_wr,
    input  logic [XLEN-1:0] msr_wdata,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] nxt_pc,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] msr,
    output logic [XLEN-1:0] srr0,
    output logic [XLEN-1:0] srr1,
    output logic [XLEN-1:0] hsrr0,
    output logic [XLEN-1:0] hsrr1,
    output logic [IW-1:0]   heir
);

    logic [NUM_SRC-1:0] req_vec;
    hvt_ev_e            ev;
    logic [XLEN-1:0]    msr_q;

    // Request vector in priority order; external masked by the enable bit.
    assign req_vec = {msr_wr, ext_req & msr_q[EE_POS], rfi_req, hrfi_req,
                      trap_req, algn_req, ill_req};

    hvt_arbiter #(.NSRC(NUM_SRC)) u_arb (
        .req (req_vec),
        .win (ev)
    );

    hvt_save #(.XLEN(XLEN), .IW(IW)) u_save (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .cur_pc   (cur_pc),
        .nxt_pc   (nxt_pc),
        .msr_q    (msr_q),
        .ill_word (ill_word),
        .srr0     (srr0),
        .srr1     (srr1),
        .hsrr0    (hsrr0),
        .hsrr1    (hsrr1),
        .heir     (heir)
    );

    hvt_msr #(.XLEN(XLEN), .HV_POS(HV_POS), .EE_POS(EE_POS)) u_msr (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .wdata (msr_wdata),
        .srr1  (srr1),
        .hsrr1 (hsrr1),
        .msr_q (msr_q)
    );

    hvt_redir #(.XLEN(XLEN), .VEC_BASE(VEC_BASE)) u_redir (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .srr0        (srr0),
        .hsrr0       (hsrr0),
        .redirect    (redirect),
        .redirect_pc (redirect_pc)
    );

    assign msr = msr_q;

endmodule

// File: rtl/hv_trap_seq_chk.sv
// Property checker for hv_trap_seq, attached through bind.
// Assumes the same parameter values as the bound instance.
module hv_trap_seq_chk #(
    parameter int unsigned     XLEN     = 64,
    parameter int unsigned     IW       = 32,
    parameter int unsigned     HV_POS   = 60,
    parameter int unsigned     EE_POS   = 15,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ill_req,
    input logic [IW-1:0]   ill_word,
    input logic            algn_req,
    input logic            trap_req,
    input logic            ext_req,
    input logic            rfi_req,
    input logic            hrfi_req,
    input logic            redirect,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] msr,
    input logic [XLEN-1:0] srr0,
    input logic [XLEN-1:0] srr1,
    input logic [IW-1:0]   heir
);

    logic sync_any;
    assign sync_any = ill_req | algn_req | trap_req | rfi_req | hrfi_req;

    // R2: hypervisor bit never reads as zero
    p_hv_pinned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        msr[HV_POS]);

    // R3: illegal request vectors to the emulation-assist offset
    p_emul_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ill_req) |-> redirect && (redirect_pc == VEC_BASE + XLEN'(12'hE40)));

    // R3: capture register takes the illegal word
    p_heir_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ill_req) |-> heir == $past(ill_word));

    // R3: ordinary pair untouched by the emulation-assist entry
    p_srr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ill_req) |-> $stable(srr0) && $stable(srr1));

    // R4: masked external produces no redirect
    p_ext_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(ext_req && !msr[EE_POS] && !sync_any) |-> !redirect);

    // R7: entries leave the external enable cleared
    p_entry_clears_ee_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && redirect && !$past(rfi_req || hrfi_req) |-> !msr[EE_POS]);

    // R10: redirect only follows an accepted request
    p_redirect_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && redirect |-> $past(sync_any || (ext_req && msr[EE_POS])));

endmodule

bind hv_trap_seq hv_trap_seq_chk #(
    .XLEN(XLEN), .IW(IW), .HV_POS(HV_POS), .EE_POS(EE_POS), .VEC_BASE(VEC_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ill_req     (ill_req),
    .ill_word    (ill_word),
    .algn_req    (algn_req),
    .trap_req    (trap_req),
    .ext_req     (ext_req),
    .rfi_req     (rfi_req),
    .hrfi_req    (hrfi_req),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .msr         (msr),
    .srr0        (srr0),
    .srr1        (srr1),
    .heir        (heir)
);

// File: tb/hv_trap_seq_test.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random traffic,
// compared against a model built from the requirements.
module hv_trap_seq_test;

    localparam logic [63:0] BASE = 64'h0;
    localparam logic [63:0] HV   = 64'h1000_0000_0000_0000;
    localparam logic [63:0] EE   = 64'h0000_0000_0000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ill_req = 0, algn_req = 0, trap_req = 0, ext_req = 0;
    logic        rfi_req = 0, hrfi_req = 0, msr_wr = 0;
    logic [31:0] ill_word = '0;
    logic [63:0] msr_wdata = '0, cur_pc = '0, nxt_pc = '0;
    logic        redirect;
    logic [63:0] redirect_pc, msr, srr0, srr1, hsrr0, hsrr1;
    logic [31:0] heir;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    logic [63:0] m_msr = HV, m_srr0 = 0, m_srr1 = 0, m_hsrr0 = 0, m_hsrr1 = 0;
    logic [31:0] m_heir = 0;
    logic        m_red = 0;
    logic [63:0] m_rpc = 0;

    always #10 clk = ~clk;

    hv_trap_seq uut (
        .clk(clk), .rst_n(rst_n), .ill_req(ill_req), .ill_word(ill_word),
        .algn_req(algn_req), .trap_req(trap_req), .ext_req(ext_req),
        .rfi_req(rfi_req), .hrfi_req(hrfi_req), .msr_wr(msr_wr),
        .msr_wdata(msr_wdata), .cur_pc(cur_pc), .nxt_pc(nxt_pc),
        .redirect(redirect), .redirect_pc(redirect_pc), .msr(msr),
        .srr0(srr0), .srr1(srr1), .hsrr0(hsrr0), .hsrr1(hsrr1), .heir(heir)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Compare every output with the model.
    task automatic compare_all(input string tag);
        chk("R2", "msr hv bit", 64'(msr[60]), 64'd1);
        chk(tag, "msr", msr, m_msr);
        chk(tag, "srr0", srr0, m_srr0);
        chk(tag, "srr1", srr1, m_srr1);
        chk(tag, "hsrr0", hsrr0, m_hsrr0);
        chk(tag, "hsrr1", hsrr1, m_hsrr1);
        chk(tag, "heir", 64'(heir), 64'(m_heir));
        chk("R10", "redirect", 64'(redirect), 64'(m_red));
        if (m_red) chk(tag, "redirect_pc", redirect_pc, m_rpc);
    endtask

    // Drive one cycle of requests (called just after a falling edge), update model, check.
    task automatic step(input logic i_ill, input logic i_al, input logic i_tr, input logic i_ex,
                        input logic i_rf, input logic i_hr, input logic i_mw,
                        input logic [63:0] wd, input string force_tag);
        int ev;
        string tag;
        logic [63:0] old_msr;
        ill_req = i_ill; algn_req = i_al; trap_req = i_tr; ext_req = i_ex;
        rfi_req = i_rf; hrfi_req = i_hr; msr_wr = i_mw; msr_wdata = wd;
        cur_pc = {$urandom, $urandom} & ~64'h3;
        nxt_pc = cur_pc + 64'd4;
        ill_word = $urandom;
        if (i_ill) ev = 1; else if (i_al) ev = 2; else if (i_tr) ev = 3;
        else if (i_hr) ev = 4; else if (i_rf) ev = 5;
        else if (i_ex && m_msr[15]) ev = 6; else if (i_mw) ev = 7; else ev = 0;
        old_msr = m_msr;
        m_red = (ev >= 1 && ev <= 6);
        case (ev)
            1: begin tag = "R3"; m_rpc = BASE + 64'hE40; m_hsrr0 = cur_pc; m_hsrr1 = old_msr; m_heir = ill_word; m_msr = old_msr & ~EE; end
            2: begin tag = "R5"; m_rpc = BASE + 64'h600; m_srr0 = cur_pc; m_srr1 = old_msr; m_msr = old_msr & ~EE; end
            3: begin tag = "R6"; m_rpc = BASE + 64'h700; m_srr0 = cur_pc; m_srr1 = old_msr; m_msr = old_msr & ~EE; end
            4: begin tag = "R8"; m_rpc = m_hsrr0; m_msr = m_hsrr1 | HV; end
            5: begin tag = "R8"; m_rpc = m_srr0; m_msr = m_srr1 | HV; end
            6: begin tag = "R4"; m_rpc = BASE + 64'h500; m_hsrr0 = nxt_pc; m_hsrr1 = old_msr; m_msr = old_msr & ~EE; end
            7: begin tag = "R11"; m_msr = wd | HV; end
            default: tag = (i_ex ? "R4" : "R10");
        endcase
        if (force_tag != "") tag = force_tag;
        @(posedge clk);
        @(negedge clk);
        ill_req = 0; algn_req = 0; trap_req = 0; ext_req = 0;
        rfi_req = 0; hrfi_req = 0; msr_wr = 0;
        compare_all(tag);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");
        // R4: external with enable clear is ignored
        step(0, 0, 0, 1, 0, 0, 0, 0, "R4");
        // R2, R11: write attempts to clear the hypervisor bit
        step(0, 0, 0, 0, 0, 0, 1, 64'h0, "R2");
        // R11: write sets enable and other bits
        step(0, 0, 0, 0, 0, 0, 1, 64'h0000_0000_0000_8031, "R11");
        // R5: alignment keeps faulting address in ordinary pair
        step(0, 1, 0, 0, 0, 0, 0, 0, "R5");
        // R7: entry cleared enable, kept low bits
        chk("R7", "msr after entry", msr, HV | 64'h31);
        // R8: return restores enable
        step(0, 0, 0, 0, 1, 0, 0, 0, "R8");
        // R4: enabled external goes to hypervisor pair
        step(0, 0, 0, 1, 0, 0, 0, 0, "R4");
        // R8: hypervisor return
        step(0, 0, 0, 0, 0, 1, 0, 0, "R8");
        // R9: everything at once, illegal wins
        step(1, 1, 1, 1, 1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
        // R9: alignment beats trap and returns
        step(0, 1, 1, 1, 1, 1, 1, 64'h0, "R9");
        // R3: lone illegal
        step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
        // R6: lone trap
        step(0, 0, 1, 0, 0, 0, 0, 0, "R6");
        // R9: hypervisor return beats normal return
        step(0, 0, 0, 0, 1, 1, 0, 0, "R9");
        for (int k = 0; k < 1500; k++) begin
            logic [7:0] r;
            r = 8'($urandom);
            step(r[2:0] == 0, r[4:2] == 1, r[5:3] == 2, $urandom_range(0, 2) == 0,
                 $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
                 $urandom_range(0, 4) == 0, {$urandom, $urandom}, "");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule